// File: doc/BRIEF.md
# Bandwidth slot-schedule builder

This block turns a set of per-client bandwidth requests into a complete slot schedule for a time-sliced memory arbiter. Every client supplies a requested slot count and an active flag, and one further input tells the block how many slots remain unclaimed by requests. A start pulse captures these inputs and begins the build.

The build runs in three phases. In the first phase, requesting clients, taken in ascending index order, have their slots spread across the schedule at a fixed interval. In the second phase, which shares that placement scan, active clients with no request each receive one slot for as long as the free-slot budget lasts. In the third phase, every slot still empty is handed out round-robin over the active clients. The finished schedule leaves the block as one write per slot, in ascending slot order. Each write carries the slot index, the client index and the region that was selected at start. A one-cycle done pulse closes the run.

Top module: `slot_sched_builder`

## Requirements
- R1: After reset, busy, done and wr_valid are all low.
- R2: Clients are placed in index order 0 to NCLI-1. A client requesting N slots (N from 1 to NSLOT) uses the interval NSLOT/N, rounded down. Its scan starts at slot 0. A taken slot moves the scan on by one. An empty slot is assigned to the client and moves the scan on by the interval. The scan ends once it reaches NSLOT.
- R3: An active client with a request of 0 receives exactly one slot, the first empty one, provided the free-slot budget is above zero at its turn. Each such grant lowers the budget by one. Once the budget reaches zero, later zero-request clients receive no slot in placement.
- R4: An inactive client with a request of 0 receives no slot in placement. When at least one client is active, it never appears in the schedule.
- R5: Each slot left empty after placement is filled with the next active client in a rotating order. The pointer starts at client 0 and moves past the client just chosen. Slots that were already placed do not move the pointer.
- R6: When no client is active, each empty slot receives the client the rotating pointer currently holds, and the pointer then advances by one, wrapping from NCLI-1 to 0.
- R7: A build emits exactly NSLOT writes on consecutive cycles, with slot indices 0 to NSLOT-1 in ascending order. Each client index is below NCLI, and each write carries the region captured at start.
- R8: done is high for exactly one cycle, in the cycle after the write of slot NSLOT-1.
- R9: The inputs are captured on the start pulse. A start pulse, or any change to the inputs, while busy is high has no effect on the running build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a build when idle |
| region | input | 1 | Target table, captured at start |
| req_cnt | input | NCLI x 7 | Requested slot count for each client (0 to NSLOT) |
| active | input | NCLI | Active flag for each client |
| free_cnt | input | 7 | Budget of unclaimed slots for zero-request clients |
| busy | output | 1 | Build in progress |
| done | output | 1 | One-cycle pulse when the build has finished |
| wr_valid | output | 1 | A schedule write is present this cycle |
| wr_region | output | 1 | Region of the write |
| wr_slot | output | 6 | Slot index of the write |
| wr_client | output | 4 | Client index assigned to the slot |

## Verification
The assertions watch the shape of the output stream on every cycle. Slot indices must start at zero and climb by one from write to write, client indices must stay in range, writes may appear only while busy is high, and done must follow the final slot for exactly one cycle. The contents of the schedule can only be shown by the bench's scenarios, which compare every write against an independently computed table. These contents are the interval spacing around taken slots, the budget-limited single grants, the exclusion of inactive clients, and the rotation of the fill pointer with and without active clients. The scenarios also show that a second start and changed inputs in the middle of a run leave the schedule unchanged.

// File: rtl/slot_sched_builder.sv
module slot_sched_builder #(
  parameter int NCLI  = 14,
  parameter int NSLOT = 64,
  localparam int SW   = $clog2(NSLOT),
  localparam int RW   = SW + 1,
  localparam int CW   = $clog2(NCLI)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     region,
  input  logic [NCLI-1:0][RW-1:0]  req_cnt,
  input  logic [NCLI-1:0]          active,
  input  logic [RW-1:0]            free_cnt,
  output logic                     busy,
  output logic                     done,
  output logic                     wr_valid,
  output logic                     wr_region,
  output logic [SW-1:0]            wr_slot,
  output logic [CW-1:0]            wr_client
);

  localparam int CIW = $clog2(NCLI + 1);

  typedef enum logic [1:0] {S_IDLE, S_PLACE, S_FILL, S_FIN} state_t;
  state_t state;

  logic [NCLI-1:0][RW-1:0] req_q;
  logic [NCLI-1:0]         act_q;
  logic [RW-1:0]           free_q;
  logic                    reg_q;
  logic [CIW-1:0]          cli;
  logic [RW-1:0]           pos;
  logic [SW-1:0]           fslot;
  logic [CW-1:0]           rr;
  logic [NSLOT-1:0]        taken;
  logic [CW-1:0]           tbl [NSLOT];

  logic [CW-1:0] cidx;
  logic [RW-1:0] cur_req, interval;
  logic          cur_zero, skip, place_hit;
  logic [CW-1:0] rr_pick, rr_next, fill_client;

  assign busy      = (state != S_IDLE);
  assign cidx      = (cli < CIW'(NCLI)) ? cli[CW-1:0] : '0;
  assign cur_req   = req_q[cidx];
  assign cur_zero  = (cur_req == '0);
  assign skip      = cur_zero && (!act_q[cidx] || free_q == '0);
  assign interval  = cur_zero ? RW'(NSLOT) : RW'(NSLOT) / (cur_zero ? RW'(1) : cur_req);
  assign place_hit = (state == S_PLACE) && (cli < CIW'(NCLI)) && !skip &&
                     (pos < RW'(NSLOT)) && !taken[pos[SW-1:0]];

  always_comb begin
    logic found;
    found   = 1'b0;
    rr_pick = rr;
    for (int k = 0; k < NCLI; k++) begin
      int t;
      t = int'(rr) + k;
      if (t >= NCLI) t = t - NCLI;
      if (!found && act_q[t]) begin
        rr_pick = CW'(t);
        found   = 1'b1;
      end
    end
  end

  assign rr_next     = (rr_pick == CW'(NCLI - 1)) ? '0 : rr_pick + 1'b1;
  assign fill_client = taken[fslot] ? tbl[fslot] : rr_pick;

  always_ff @(posedge clk)
    if (place_hit) tbl[pos[SW-1:0]] <= cidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      req_q <= '0; act_q <= '0; free_q <= '0; reg_q <= 1'b0;
      cli <= '0; pos <= '0; fslot <= '0; rr <= '0; taken <= '0;
      done <= 1'b0; wr_valid <= 1'b0; wr_region <= 1'b0;
      wr_slot <= '0; wr_client <= '0;
    end else begin
      done     <= 1'b0;
      wr_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          req_q <= req_cnt; act_q <= active; free_q <= free_cnt; reg_q <= region;
          taken <= '0; cli <= '0; pos <= '0;
          state <= S_PLACE;
        end
        S_PLACE: begin
          if (cli == CIW'(NCLI)) begin
            fslot <= '0; rr <= '0;
            state <= S_FILL;
          end else if (skip || pos >= RW'(NSLOT)) begin
            cli <= cli + 1'b1;
            pos <= '0;
          end else if (taken[pos[SW-1:0]]) begin
            pos <= pos + 1'b1;
          end else begin
            taken[pos[SW-1:0]] <= 1'b1;
            pos <= pos + interval;
            if (cur_zero) free_q <= free_q - 1'b1;
          end
        end
        S_FILL: begin
          wr_valid  <= 1'b1;
          wr_region <= reg_q;
          wr_slot   <= fslot;
          wr_client <= fill_client;
          if (!taken[fslot]) rr <= rr_next;
          if (fslot == SW'(NSLOT - 1)) state <= S_FIN;
          else fslot <= fslot + 1'b1;
        end
        default: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  AST_FIRST_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !$past(wr_valid) |-> wr_slot == '0); // R7
  AST_SLOT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && $past(wr_valid) |-> wr_slot == $past(wr_slot) + 1'b1); // R7
  AST_CLIENT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_client < CW'(NCLI)); // R7
  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_valid) && $past(wr_slot) == SW'(NSLOT - 1)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUDGET_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PLACE) && $past(state == S_PLACE) |-> free_q <= $past(free_q)); // R3

endmodule

// File: tb/slot_sched_builder_bench.sv
module slot_sched_builder_bench;
  localparam int NCLI = 14;
  localparam int NSLOT = 64;
  localparam int SW = $clog2(NSLOT);
  localparam int RW = SW + 1;
  localparam int CW = $clog2(NCLI);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic region = 1'b0;
  logic [NCLI-1:0][RW-1:0] req_cnt = '0;
  logic [NCLI-1:0] active = '0;
  logic [RW-1:0] free_cnt = '0;
  logic busy, done, wr_valid, wr_region;
  logic [SW-1:0] wr_slot;
  logic [CW-1:0] wr_client;

  slot_sched_builder #(.NCLI(NCLI), .NSLOT(NSLOT)) u_slot_sched_builder (
    .clk(clk), .rst_n(rst_n), .start(start), .region(region),
    .req_cnt(req_cnt), .active(active), .free_cnt(free_cnt),
    .busy(busy), .done(done), .wr_valid(wr_valid), .wr_region(wr_region),
    .wr_slot(wr_slot), .wr_client(wr_client));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m_req [NCLI];
  bit m_act [NCLI];
  int m_free;
  int exp_tab [NSLOT];
  int q_slot[$], q_cli[$], q_reg[$];
  int banned = -1;
  int writes = 0, dones = 0;
  bit prev_valid = 0;
  int prev_slot = 0;

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  function automatic void model();
    int free, rr, iv, pos;
    bit anyact;
    free = m_free;
    for (int s = 0; s < NSLOT; s++) exp_tab[s] = -1;
    for (int c = 0; c < NCLI; c++) begin
      if (m_req[c] == 0) begin
        if (!m_act[c] || free <= 0) continue;
        free--;
        iv = NSLOT;
      end else iv = NSLOT / m_req[c];
      pos = 0;
      while (pos < NSLOT) begin
        if (exp_tab[pos] >= 0) pos++;
        else begin exp_tab[pos] = c; pos += iv; end
      end
    end
    anyact = 0;
    for (int c = 0; c < NCLI; c++) anyact |= m_act[c];
    rr = 0;
    for (int s = 0; s < NSLOT; s++) begin
      if (exp_tab[s] < 0) begin
        if (anyact) while (!m_act[rr]) rr = (rr + 1) % NCLI;
        exp_tab[s] = rr;
        rr = (rr + 1) % NCLI;
      end
    end
  endfunction

  task automatic run(input int reg_sel, input bit disturb);
    model();
    for (int s = 0; s < NSLOT; s++) begin
      q_slot.push_back(s); q_cli.push_back(exp_tab[s]); q_reg.push_back(reg_sel);
    end
    @(posedge clk); #1;
    for (int c = 0; c < NCLI; c++) begin
      req_cnt[c] = RW'(m_req[c]); active[c] = m_act[c];
    end
    free_cnt = RW'(m_free); region = reg_sel[0]; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    writes = 0; dones = 0;
    if (disturb) begin
      repeat (30) @(posedge clk);
      #1;
      req_cnt = '0; active = '1; free_cnt = RW'(NSLOT); region = ~region; start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q_slot.size() == 0, "R7 leftover expected writes", q_slot.size(), 0);
    chk(writes == NSLOT, "R7 write count", writes, NSLOT);
    chk(dones == 1, disturb ? "R9 done count" : "R8 done count", dones, 1);
    chk(!busy, "R8 idle after done", busy, 0);
    q_slot.delete(); q_cli.delete(); q_reg.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      writes++;
      if (q_slot.size() == 0) chk(0, "R7 unexpected write", wr_slot, -1);
      else begin
        int es, ec, er;
        es = q_slot.pop_front(); ec = q_cli.pop_front(); er = q_reg.pop_front();
        chk(int'(wr_slot) == es, "R7 slot index", wr_slot, es);
        chk(int'(wr_client) == ec, "R2/R3/R5/R6 client", wr_client, ec);
        chk(int'(wr_region) == er, "R7 region", wr_region, er);
        if (banned >= 0) chk(int'(wr_client) != banned, "R4 inactive client", wr_client, banned);
      end
    end
    if (rst_n && done) begin
      dones++;
      chk(prev_valid && prev_slot == NSLOT - 1, "R8 done after last slot", prev_slot, NSLOT - 1);
    end
    prev_valid = wr_valid;
    prev_slot = wr_slot;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic clear();
    for (int c = 0; c < NCLI; c++) begin m_req[c] = 0; m_act[c] = 0; end
    m_free = 0; banned = -1;
  endtask

  initial begin
    clear();
    repeat (3) @(posedge clk);
    #1;
    chk(!busy, "R1 busy at reset", busy, 0);
    chk(!done, "R1 done at reset", done, 0);
    chk(!wr_valid, "R1 wr_valid at reset", wr_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(!busy && !wr_valid, "R1 idle after reset", busy, 0);

    // R6: nobody active, pointer client cycles 0..13
    clear();
    run(0, 0);

    // R2 R3 R4 R5: interval placement, single grants, fill over actives
    clear();
    m_req[0] = 4; m_req[2] = 3;
    m_act[0] = 1; m_act[2] = 1; m_act[5] = 1; m_act[9] = 1;
    m_free = 57; banned = 1;
    run(1, 0);

    // R3: budget of one, only the first zero-request active client gets a grant
    clear();
    m_req[0] = 32; m_req[6] = 5;
    m_act[0] = 1; m_act[3] = 1; m_act[4] = 1; m_act[7] = 1; m_act[6] = 1;
    m_free = 1; banned = 2;
    run(1, 0);

    // R2: full request fills every slot
    clear();
    m_req[6] = 64; m_act[6] = 1; m_act[1] = 1; m_free = 5;
    run(0, 0);

    // R2 R5: odd intervals colliding with taken slots
    clear();
    m_req[1] = 7; m_req[4] = 9; m_req[12] = 10;
    m_act[1] = 1; m_act[4] = 1; m_act[12] = 1; m_act[13] = 1;
    m_free = 30; banned = 0;
    run(0, 0);

    // R9: second start and changed inputs while busy are ignored
    clear();
    m_req[3] = 16; m_act[3] = 1; m_act[8] = 1; m_act[10] = 1; m_act[11] = 1;
    m_free = 2; banned = 5;
    run(1, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule